// File: doc/BRIEF.md
# Amplitude Window Controller

This block is the digital half of an oscillator's automatic amplitude loop. Two analog comparators watch a peak detector: one reports that the amplitude is above a high reference, the other that it is below a low reference. After a start pulse, the controller waits a programmable settle time and then reads both flags. If the amplitude is too high it lowers the bias-current code by one step. If it is too low it raises the code by one step. It repeats this until the amplitude sits between the two references, and then it stops with lock reported.

The two reference levels come from a resistor-ladder generator. The controller holds the two ladder selection codes in writable registers and keeps the low code strictly below the high code. If one bias step is too coarse for the window, the amplitude can bounce across the window without end. The controller counts reversals of step direction and gives up with an error after a set number of them. A run also ends when both flags are seen at once, which is an invalid input, and when the code is pinned at a rail while being pushed further.

Top module: `amp_win_ctrl`

## Requirements
- R1: Reset state:
  - the bias code is BIAS_RST (default 32);
  - the low selection is 4 and the high selection is 12;
  - busy, done, lock and both error outputs are low.
- R2: Settle timing:
  - a start loads the settle count S from settle_cycles_i;
  - the first decision is taken S+1 clock edges after the start edge;
  - each later decision is taken S+1 edges after the previous one;
  - done rises on the edge of the final decision.
- R3: At a decision with only amp_hi_i set, the bias code decreases by exactly one. With only amp_lo_i set, it increases by exactly one.
- R4: At a decision with neither flag set:
  - the run ends with done and lock high and busy low;
  - the code then holds until the next start.
- R5: The code saturates at 0 and at 2^BIAS_W-1. A decision that would push it past either rail ends the run with done high, lock low, no error flag, and the code left at the rail.
- R6: Hunting:
  - a reversal is a step request opposite in direction to the previous request of the same run;
  - the request that would make the HUNT_LIMIT-th reversal (default 4) is not applied;
  - instead the run ends with hunt_err_o and done high, lock low, and the last applied code kept.
- R7: At a decision with both flags set, the code is held and the run ends with flag_err_o and done high and lock low.
- R8: A start pulse, even in the middle of a run:
  - restarts the search from the present code;
  - clears done, lock, both error flags and the reversal history;
  - raises busy on the next cycle.
- R9: When idle, a write with cfg_sel_hi_i=0 loads cfg_data_i into the low selection, and one with cfg_sel_hi_i=1 loads the high selection. The new value is visible on the cycle after the write edge.
- R10: A selection write sampled while busy is high is ignored.
- R11: A selection write is ignored if it would leave the low selection greater than or equal to the high selection. The low selection therefore always stays strictly below the high selection.
- R12: busy_o and done_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start or restart pulse |
| settle_cycles_i | input | SETTLE_W | Extra cycles to wait before each decision |
| amp_hi_i | input | 1 | Amplitude is above the high reference |
| amp_lo_i | input | 1 | Amplitude is below the low reference |
| cfg_we_i | input | 1 | Selection register write strobe |
| cfg_sel_hi_i | input | 1 | 0 writes the low selection, 1 writes the high selection |
| cfg_data_i | input | REF_W | Selection write data |
| ref_lo_sel_o | output | REF_W | Low reference ladder selection |
| ref_hi_sel_o | output | REF_W | High reference ladder selection |
| bias_code_o | output | BIAS_W | Bias-current code |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | Last run has ended |
| lock_o | output | 1 | Last run ended inside the window |
| hunt_err_o | output | 1 | Last run ended on hunting |
| flag_err_o | output | 1 | Last run ended on both flags set |

## Verification
The bench closes the loop with a behavioural amplitude model. The model raises the low flag below one code threshold and the high flag above another, so each run's final code, end kind and length in cycles can be predicted.

It drives the code into both rails. A controller that wrapped at a rail would jump to the far end, and one that did not stop there would never raise done. It sets up a one-code gap between the thresholds so that the loop hunts. A miscounted reversal limit then shows up as a wrong final code or a wrong cycle count.

It also covers these cases:
- Both flags set at once, where a faulty design would step the code or report lock.
- A restart in the middle of a run, whose length must be counted from the restart.
- Selection writes made while busy or that would cross the low code over the high one, including the equal boundary. A design that accepted them would show the changed selection at its outputs.

// File: rtl/amp_win_pkg.sv
package amp_win_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } ctl_state_e;

  typedef struct packed {
    logic lock;
    logic hunt;
    logic flag;
  } end_stat_t;

endpackage

// File: rtl/amp_win_regs.sv
module amp_win_regs #(
  parameter int unsigned REF_W  = 4,
  parameter int unsigned LO_RST = 4,
  parameter int unsigned HI_RST = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             sel_hi_i,
  input  logic [REF_W-1:0] data_i,
  input  logic             hold_i,
  output logic [REF_W-1:0] lo_o,
  output logic [REF_W-1:0] hi_o
);

  logic [REF_W-1:0] lo_q, hi_q;
  logic             lo_ok, hi_ok;

  // keep strict ordering lo < hi
  assign lo_ok = data_i < hi_q;
  assign hi_ok = data_i > lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= LO_RST[REF_W-1:0];
      hi_q <= HI_RST[REF_W-1:0];
    end else if (we_i && !hold_i) begin
      if (sel_hi_i) begin
        if (hi_ok) hi_q <= data_i;
      end else begin
        if (lo_ok) lo_q <= data_i;
      end
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;

endmodule

// File: rtl/amp_win_bias.sv
module amp_win_bias #(
  parameter int unsigned BIAS_W   = 6,
  parameter int unsigned BIAS_RST = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              dn_i,
  output logic [BIAS_W-1:0] code_o,
  output logic              at_min_o,
  output logic              at_max_o
);

  localparam logic [BIAS_W-1:0] CODE_MAX = '1;
  localparam logic [BIAS_W-1:0] CODE_ONE = BIAS_W'(1);

  logic [BIAS_W-1:0] code_q;

  assign at_min_o = (code_q == '0);
  assign at_max_o = (code_q == CODE_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= BIAS_RST[BIAS_W-1:0];
    end else if (step_i) begin
      if (dn_i) begin
        if (!at_min_o) code_q <= code_q - CODE_ONE;
      end else begin
        if (!at_max_o) code_q <= code_q + CODE_ONE;
      end
    end
  end

  assign code_o = code_q;

endmodule

// File: rtl/amp_win_hunt.sv
module amp_win_hunt #(
  parameter int unsigned HUNT_LIMIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic req_i,
  input  logic dn_i,
  output logic hit_o
);

  localparam int unsigned REV_W = $clog2(HUNT_LIMIT + 1);
  localparam logic [REV_W-1:0] REV_LAST = REV_W'(HUNT_LIMIT - 1);
  localparam logic [REV_W-1:0] REV_ONE  = REV_W'(1);

  logic             have_dir_q;
  logic             last_dn_q;
  logic [REV_W-1:0] rev_q;
  logic             reversal;

  assign reversal = req_i && have_dir_q && (dn_i != last_dn_q);
  assign hit_o    = reversal && (rev_q == REV_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_dir_q <= 1'b0;
      last_dn_q  <= 1'b0;
      rev_q      <= '0;
    end else if (clr_i) begin
      have_dir_q <= 1'b0;
      last_dn_q  <= 1'b0;
      rev_q      <= '0;
    end else if (req_i) begin
      have_dir_q <= 1'b1;
      last_dn_q  <= dn_i;
      if (reversal) rev_q <= rev_q + REV_ONE;
    end
  end

endmodule

// File: rtl/amp_win_fsm.sv
module amp_win_fsm
  import amp_win_pkg::*;
#(
  parameter int unsigned SETTLE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic                hi_i,
  input  logic                lo_i,
  input  logic                at_min_i,
  input  logic                at_max_i,
  input  logic                hit_i,
  output logic                step_o,
  output logic                dn_o,
  output logic                req_o,
  output logic                clr_o,
  output logic                busy_o,
  output logic                done_o,
  output end_stat_t           stat_o
);

  localparam logic [SETTLE_W-1:0] CNT_ONE = SETTLE_W'(1);

  ctl_state_e          state_q;
  logic [SETTLE_W-1:0] cnt_q;
  end_stat_t           stat_q;
  logic                decide, both, none, sat;

  assign decide = (state_q == ST_RUN) && (cnt_q == '0) && !start_i;
  assign both   = hi_i && lo_i;
  assign none   = !hi_i && !lo_i;
  assign dn_o   = hi_i;
  assign sat    = hi_i ? at_min_i : at_max_i;
  assign req_o  = decide && !both && !none;
  assign step_o = req_o && !hit_i && !sat;
  assign clr_o  = start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      stat_q  <= '0;
    end else if (start_i) begin
      state_q <= ST_RUN;
      cnt_q   <= settle_i;
      stat_q  <= '0;
    end else if (state_q == ST_RUN) begin
      if (cnt_q != '0) begin
        cnt_q <= cnt_q - CNT_ONE;
      end else if (both) begin
        state_q     <= ST_DONE;
        stat_q.flag <= 1'b1;
      end else if (none) begin
        state_q     <= ST_DONE;
        stat_q.lock <= 1'b1;
      end else if (hit_i) begin
        state_q     <= ST_DONE;
        stat_q.hunt <= 1'b1;
      end else if (sat) begin
        state_q <= ST_DONE;
      end else begin
        cnt_q <= settle_i;
      end
    end
  end

  assign busy_o = (state_q == ST_RUN);
  assign done_o = (state_q == ST_DONE);
  assign stat_o = stat_q;

endmodule

// File: rtl/amp_win_ctrl.sv
module amp_win_ctrl
  import amp_win_pkg::*;
#(
  parameter int unsigned BIAS_W     = 6,
  parameter int unsigned BIAS_RST   = 32,
  parameter int unsigned REF_W      = 4,
  parameter int unsigned REF_LO_RST = 4,
  parameter int unsigned REF_HI_RST = 12,
  parameter int unsigned SETTLE_W   = 8,
  parameter int unsigned HUNT_LIMIT = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [SETTLE_W-1:0] settle_cycles_i,
  input  logic                amp_hi_i,
  input  logic                amp_lo_i,
  input  logic                cfg_we_i,
  input  logic                cfg_sel_hi_i,
  input  logic [REF_W-1:0]    cfg_data_i,
  output logic [REF_W-1:0]    ref_lo_sel_o,
  output logic [REF_W-1:0]    ref_hi_sel_o,
  output logic [BIAS_W-1:0]   bias_code_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                lock_o,
  output logic                hunt_err_o,
  output logic                flag_err_o
);

  logic      step, dn, req, clr, at_min, at_max, hit;
  end_stat_t stat;

  amp_win_regs #(
    .REF_W (REF_W),
    .LO_RST(REF_LO_RST),
    .HI_RST(REF_HI_RST)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .sel_hi_i(cfg_sel_hi_i),
    .data_i  (cfg_data_i),
    .hold_i  (busy_o),
    .lo_o    (ref_lo_sel_o),
    .hi_o    (ref_hi_sel_o)
  );

  amp_win_bias #(
    .BIAS_W  (BIAS_W),
    .BIAS_RST(BIAS_RST)
  ) u_bias (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step),
    .dn_i    (dn),
    .code_o  (bias_code_o),
    .at_min_o(at_min),
    .at_max_o(at_max)
  );

  amp_win_hunt #(
    .HUNT_LIMIT(HUNT_LIMIT)
  ) u_hunt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .req_i (req),
    .dn_i  (dn),
    .hit_o (hit)
  );

  amp_win_fsm #(
    .SETTLE_W(SETTLE_W)
  ) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .settle_i(settle_cycles_i),
    .hi_i    (amp_hi_i),
    .lo_i    (amp_lo_i),
    .at_min_i(at_min),
    .at_max_i(at_max),
    .hit_i   (hit),
    .step_o  (step),
    .dn_o    (dn),
    .req_o   (req),
    .clr_o   (clr),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .stat_o  (stat)
  );

  assign lock_o     = stat.lock;
  assign hunt_err_o = stat.hunt;
  assign flag_err_o = stat.flag;

endmodule

// File: rtl/amp_win_chk.sv
module amp_win_chk #(
  parameter int unsigned BIAS_W = 6,
  parameter int unsigned REF_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [REF_W-1:0]  ref_lo_sel_o,
  input logic [REF_W-1:0]  ref_hi_sel_o,
  input logic [BIAS_W-1:0] bias_code_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              lock_o,
  input logic              hunt_err_o,
  input logic              flag_err_o
);

  localparam logic [BIAS_W-1:0] ONE = BIAS_W'(1);

  a_r3_unit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bias_code_o) |->
      ((bias_code_o == $past(bias_code_o) + ONE) || (bias_code_o == $past(bias_code_o) - ONE)));

  a_r4_hold_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> $stable(bias_code_o));

  a_r6_hunt_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hunt_err_o |-> (done_o && !lock_o));

  a_r7_flag_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_err_o |-> (done_o && !lock_o && !hunt_err_o));

  a_r8_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (busy_o && !done_o && !lock_o && !hunt_err_o && !flag_err_o));

  a_r10_busy_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(ref_lo_sel_o) && $stable(ref_hi_sel_o)));

  a_r11_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_lo_sel_o < ref_hi_sel_o);

  a_r12_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

endmodule

bind amp_win_ctrl amp_win_chk #(
  .BIAS_W(BIAS_W),
  .REF_W (REF_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .ref_lo_sel_o(ref_lo_sel_o),
  .ref_hi_sel_o(ref_hi_sel_o),
  .bias_code_o (bias_code_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .lock_o      (lock_o),
  .hunt_err_o  (hunt_err_o),
  .flag_err_o  (flag_err_o)
);

// File: tb/amp_win_ctrl_tb.sv
module amp_win_ctrl_tb;

  localparam int BIAS_W     = 6;
  localparam int BIAS_MAX   = (1 << BIAS_W) - 1;
  localparam int REF_W      = 4;
  localparam int SETTLE_W   = 8;
  localparam int HUNT_LIMIT = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                rst_n = 1'b0;
  logic                start = 1'b0;
  logic [SETTLE_W-1:0] settle = '0;
  logic                amp_hi, amp_lo;
  logic                cfg_we = 1'b0;
  logic                cfg_sel_hi = 1'b0;
  logic [REF_W-1:0]    cfg_data = '0;
  logic [REF_W-1:0]    ref_lo, ref_hi;
  logic [BIAS_W-1:0]   bias_code;
  logic                busy, done, lock, hunt_err, flag_err;

  // amplitude plant model
  int lo_thr = 0;
  int hi_thr = BIAS_MAX;
  bit force_both = 1'b0;
  assign amp_lo = force_both || (int'(bias_code) < lo_thr);
  assign amp_hi = force_both || (int'(bias_code) > hi_thr);

  amp_win_ctrl u_dut (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .start_i        (start),
    .settle_cycles_i(settle),
    .amp_hi_i       (amp_hi),
    .amp_lo_i       (amp_lo),
    .cfg_we_i       (cfg_we),
    .cfg_sel_hi_i   (cfg_sel_hi),
    .cfg_data_i     (cfg_data),
    .ref_lo_sel_o   (ref_lo),
    .ref_hi_sel_o   (ref_hi),
    .bias_code_o    (bias_code),
    .busy_o         (busy),
    .done_o         (done),
    .lock_o         (lock),
    .hunt_err_o     (hunt_err),
    .flag_err_o     (flag_err)
  );

  typedef struct {
    string tag;
    int    code;
    bit    lock;
    bit    hunt;
    bit    flag;
    int    cycles;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   fails = 0;

  task automatic check(string req, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // reference model from the requirements
  function automatic exp_t model(int c, int s, string tag);
    exp_t e;
    int   rev = 0;
    int   dir = 0;
    int   n = 0;
    e.tag = tag; e.lock = 0; e.hunt = 0; e.flag = 0;
    while (1) begin
      bit h, l;
      int d;
      h = force_both || (c > hi_thr);
      l = force_both || (c < lo_thr);
      n++;
      if (h && l) begin e.flag = 1; break; end
      if (!h && !l) begin e.lock = 1; break; end
      d = h ? -1 : 1;
      if (dir != 0 && d != dir) begin
        rev++;
        if (rev == HUNT_LIMIT) begin e.hunt = 1; break; end
      end
      if ((d < 0 && c == 0) || (d > 0 && c == BIAS_MAX)) break;
      c += d;
      dir = d;
    end
    e.code = c;
    e.cycles = n * (s + 1);
    return e;
  endfunction

  task automatic wait_idle();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_case(int s, bit wait_end, string tag);
    exp_t e;
    @(negedge clk);
    e = model(int'(bias_code), s, tag);
    exp_q.push_back(e);
    settle = SETTLE_W'(s);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (wait_end) wait_idle();
  endtask

  task automatic cfg_write(bit sel_hi, int data);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_sel_hi = sel_hi;
    cfg_data = REF_W'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // monitor / scoreboard
  int   cyc = 0;
  bit   prev_done = 1'b0;
  exp_t mon_e;
  always @(posedge clk) begin
    if (start) cyc = 0;
    else cyc++;
    #1;
    if (rst_n && done && !prev_done) begin
      if (exp_q.size() == 0) begin
        check("R4", "unexpected done", 1, 0);
      end else begin
        mon_e = exp_q.pop_front();
        check(mon_e.tag, "final code", int'(bias_code), mon_e.code);
        check(mon_e.tag, "lock", int'(lock), int'(mon_e.lock));
        check(mon_e.tag, "hunt_err", int'(hunt_err), int'(mon_e.hunt));
        check(mon_e.tag, "flag_err", int'(flag_err), int'(mon_e.flag));
        check("R2", "cycles start to done", cyc, mon_e.cycles);
        check("R12", "busy at done", int'(busy), 0);
      end
    end
    prev_done = done;
  end

  bit finished = 1'b0;
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R2 watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset code", int'(bias_code), 32);
    check("R1", "reset busy", int'(busy), 0);
    check("R1", "reset done", int'(done), 0);
    check("R1", "reset lock", int'(lock), 0);
    check("R1", "reset errors", int'(hunt_err) + int'(flag_err), 0);
    check("R1", "reset lo sel", int'(ref_lo), 4);
    check("R1", "reset hi sel", int'(ref_hi), 12);
    rst_n = 1'b1;
    @(negedge clk);

    cfg_write(1'b0, 2);
    check("R9", "lo sel write", int'(ref_lo), 2);
    cfg_write(1'b1, 14);
    check("R9", "hi sel write", int'(ref_hi), 14);
    cfg_write(1'b0, 14);
    check("R11", "lo equal hi rejected", int'(ref_lo), 2);
    cfg_write(1'b1, 1);
    check("R11", "hi below lo rejected", int'(ref_hi), 14);

    // upward lock, settle 3
    lo_thr = 36; hi_thr = 40;
    run_case(3, 1'b1, "R3");
    repeat (4) @(negedge clk);
    check("R4", "code held after lock", int'(bias_code), 36);
    check("R4", "done held", int'(done), 1);

    // downward lock, settle 0
    lo_thr = 20; hi_thr = 25;
    run_case(0, 1'b1, "R3");

    // writes while busy
    lo_thr = 30; hi_thr = 31;
    run_case(5, 1'b0, "R4");
    repeat (2) @(negedge clk);
    cfg_write(1'b0, 5);
    check("R10", "lo write while busy", int'(ref_lo), 2);
    cfg_write(1'b1, 9);
    check("R10", "hi write while busy", int'(ref_hi), 14);
    wait_idle();

    // hunting: one-code gap
    lo_thr = 33; hi_thr = 32;
    run_case(1, 1'b1, "R6");
    check("R6", "hunt flag held", int'(hunt_err), 1);

    // both flags; start clears error
    force_both = 1'b1;
    run_case(2, 1'b0, "R7");
    check("R8", "hunt_err cleared by start", int'(hunt_err), 0);
    check("R8", "busy after start", int'(busy), 1);
    wait_idle();
    force_both = 1'b0;

    // saturation at max and min
    lo_thr = 100; hi_thr = 200;
    run_case(0, 1'b1, "R5");
    lo_thr = -1; hi_thr = -1;
    run_case(0, 1'b1, "R5");

    // restart mid-run
    lo_thr = 12; hi_thr = 14;
    @(negedge clk);
    settle = SETTLE_W'(4);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (12) @(negedge clk);
    check("R8", "still busy before restart", int'(busy), 1);
    run_case(4, 1'b1, "R8");

    // longer settle, upward
    lo_thr = 20; hi_thr = 22;
    run_case(7, 1'b1, "R2");

    cfg_write(1'b0, 3);
    check("R9", "lo write when idle", int'(ref_lo), 3);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule